// File: doc/BRIEF.md
# Store Queue with Load Bypass and Forwarding

This block sits between a load/store unit and the data memory port. Stores enter in program order and wait in a circular queue until they are retired. Entries that have been executed but not yet retired form the finished region. Retired entries form the completed region. Only completed entries are written to memory, oldest first, and only in cycles where no load needs the port.

Each load checks its full word address against every queued store, finished or completed. The memory read is issued in the same cycle as this check. If no store has the same address, the load bypasses the queue and returns the memory word. If one or more stores match, the memory word is discarded and the data of the youngest matching store is returned. The load result appears one cycle after the request.

All accesses are whole, aligned words, and addresses are word indices.

Top module: `sb_store_buffer`

## Requirements
- R1: During and right after reset the queue is empty: `st_ready_o`=1, `mem_req_o`=0, `ld_valid_o`=0.
- R2: A store that has not been retired through `cmt_i` never produces a memory write (`mem_we_o`=1).
- R3: Completed stores are written to memory one per cycle, oldest first, with their own address and data. A write happens in every cycle that has no load and at least one completed entry. A retire pulse takes effect at the clock edge, so it cannot cause a write in its own cycle.
- R4: In a cycle with `ld_valid_i`=1 the memory port performs that read (`mem_req_o`=1, `mem_we_o`=0, `mem_addr_o`=load address), and no store is drained.
- R5: A load whose address matches no queued store returns the memory word, with `ld_fwd_o`=0, in the cycle after the request (`ld_valid_o`=1).
- R6: A load whose address matches one or more queued stores returns the data of the youngest match, with `ld_fwd_o`=1, one cycle after the request.
- R7: Matching compares every address bit, so two addresses that differ only in the top bit never match.
- R8: When the queue holds DEPTH entries, `st_ready_o`=0 and an offered store is dropped. It is not visible to later loads.
- R9: The youngest match is chosen correctly when the queue contents wrap past the last slot.
- R10: A store accepted in the same cycle as a load counts as younger than that load and is not forwarded to it.
- R11: A `cmt_i` pulse while no finished entry exists has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| st_ready_o | output | 1 | Queue can accept a store |
| cmt_i | input | 1 | Retire the oldest finished store |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | AW | Load word address |
| ld_valid_o | output | 1 | Load result valid (one cycle after request) |
| ld_fwd_o | output | 1 | Result came from a queued store |
| ld_data_o | output | DW | Load result |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, one cycle after a read request |

## Verification
Loads are tried against four kinds of queue contents, each telling a different case apart:
- no matching store, which shows bypass to memory;
- one match, which shows plain forwarding;
- several stores to the same address, which shows the youngest is chosen rather than the oldest or the memory copy;
- a store whose address differs only in the top bit, which shows the compare covers the full address.

A second several-match case places the younger store in slot 0, after the pointers wrap. A search ordered by slot index would then pick the older entry.

Drain patterns interleave retires, loads and idle cycles. These show that unretired stores stay out of memory, that a load blocks a pending drain, and that repeated writes to one address reach memory in program order.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    MEM_IDLE = 2'd0,
    MEM_RD   = 2'd1,
    MEM_WR   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/sb_ptrs.sv
module sb_ptrs #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          commit_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] tail_o,
  output logic [PW:0]   cnt_o,
  output logic [PW:0]   cmp_cnt_o,
  output logic          full_o
);
  logic [PW:0] head_q, tail_q, cmt_q;
  logic [PW:0] fin_cnt;
  logic        push_ok, commit_ok;

  assign cnt_o     = tail_q - head_q;
  assign cmp_cnt_o = cmt_q - head_q;
  assign fin_cnt   = tail_q - cmt_q;
  assign full_o    = cnt_o == (PW+1)'(DEPTH);
  assign head_o    = head_q[PW-1:0];
  assign tail_o    = tail_q[PW-1:0];
  assign push_ok   = push_i && !full_o;
  assign commit_ok = commit_i && (fin_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cmt_q  <= '0;
    end else begin
      if (push_ok)   tail_q <= tail_q + 1'b1;
      if (commit_ok) cmt_q  <= cmt_q + 1'b1;
      if (pop_i)     head_q <= head_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> $stable(tail_q)); // R8
  AST_COMMIT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && tail_q == cmt_q) |=> $stable(cmt_q)); // R11
  AST_POP_COMPLETED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cmt_q != head_q)); // R2
  AST_DRAIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> head_q == $past(head_q) + 1'b1); // R3
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [PW-1:0] tail_i,
  input  logic [PW:0]   cnt_i,
  input  logic [AW-1:0] addr_i [DEPTH],
  input  logic [DW-1:0] data_i [DEPTH],
  input  logic [AW-1:0] ld_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] data_o
);
  // slot k of the search is the k-th youngest entry, counted back from tail
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] sel;
  logic [PW-1:0]    slot [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign slot[k] = tail_i - PW'(k + 1);
    assign cand[k] = ((PW+1)'(k) < cnt_i) && (addr_i[slot[k]] == ld_addr_i);
  end

  always_comb begin
    sel    = '0;
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (cand[k] && !hit_o) begin
        hit_o  = 1'b1;
        sel[k] = 1'b1;
        data_o = data_i[slot[k]];
      end
    end
  end

  AST_ONE_SOURCE: assert final ($onehot0(sel)); // R6
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          st_ready_o,
  input  logic          cmt_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_valid_o,
  output logic          ld_fwd_o,
  output logic [DW-1:0] ld_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [PW:0]   cnt, cmp_cnt;
  logic          full, push, pop;
  logic          hit;
  logic [DW-1:0] hit_data;
  mem_op_e       op;

  logic          ld_vld_q, hit_q;
  logic [DW-1:0] fwd_q;

  assign st_ready_o = !full;
  assign push       = st_valid_i && !full;

  sb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (st_valid_i),
    .commit_i  (cmt_i),
    .pop_i     (pop),
    .head_o    (head),
    .tail_o    (tail),
    .cnt_o     (cnt),
    .cmp_cnt_o (cmp_cnt),
    .full_o    (full)
  );

  sb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .tail_i    (tail),
    .cnt_i     (cnt),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .ld_addr_i (ld_addr_i),
    .hit_o     (hit),
    .data_o    (hit_data)
  );

  always_ff @(posedge clk_i) begin
    if (push) begin
      addr_q[tail] <= st_addr_i;
      data_q[tail] <= st_data_i;
    end
  end

  // loads own the port; completed stores drain only in otherwise idle cycles
  always_comb begin
    if (ld_valid_i)             op = MEM_RD;
    else if (cmp_cnt != '0)     op = MEM_WR;
    else                        op = MEM_IDLE;
  end

  assign pop         = op == MEM_WR;
  assign mem_req_o   = op != MEM_IDLE;
  assign mem_we_o    = op == MEM_WR;
  assign mem_addr_o  = (op == MEM_WR) ? addr_q[head] : ld_addr_i;
  assign mem_wdata_o = data_q[head];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_vld_q <= 1'b0;
      hit_q    <= 1'b0;
      fwd_q    <= '0;
    end else begin
      ld_vld_q <= ld_valid_i;
      hit_q    <= ld_valid_i && hit;
      if (ld_valid_i) fwd_q <= hit_data;
    end
  end

  // memory word arrives now; it is discarded when the alias check hit
  assign ld_valid_o = ld_vld_q;
  assign ld_fwd_o   = hit_q;
  assign ld_data_o  = hit_q ? fwd_q : mem_rdata_i;

  AST_LD_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |-> (mem_req_o && !mem_we_o && mem_addr_o == ld_addr_i)); // R4
  AST_LD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> ld_valid_o); // R5
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> !ld_valid_o && !ld_fwd_o); // R5
  AST_IDLE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_valid_i && cmp_cnt != '0) |-> mem_we_o); // R3
endmodule

// File: tb/sb_store_buffer_tb.sv
`timescale 1ns/1ps
module sb_store_buffer_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 32;

  localparam logic [1:0] OP_ST = 2'd0, OP_CM = 2'd1, OP_LD = 2'd2, OP_ID = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic        f;
  } vec_t;

  // ST: f = expected ready; CM/ID: f = expected write (a,d); LD: f = expected fwd, e = data
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{OP_ST, 8'h10, 32'd111, 32'd0,          1'b1},
    '{OP_ST, 8'h20, 32'd222, 32'd0,          1'b1},
    '{OP_LD, 8'h10, 32'd0,   32'd111,        1'b1},
    '{OP_LD, 8'h30, 32'd0,   32'hA000_0030,  1'b0},
    '{OP_ST, 8'h10, 32'd333, 32'd0,          1'b1},
    '{OP_LD, 8'h10, 32'd0,   32'd333,        1'b1},
    '{OP_ST, 8'h40, 32'd444, 32'd0,          1'b1},
    '{OP_ST, 8'h50, 32'd555, 32'd0,          1'b0},
    '{OP_LD, 8'h50, 32'd0,   32'hA000_0050,  1'b0},
    '{OP_CM, 8'h00, 32'd0,   32'd0,          1'b0},
    '{OP_LD, 8'h10, 32'd0,   32'd333,        1'b1},
    '{OP_ID, 8'h10, 32'd111, 32'd0,          1'b1},
    '{OP_ID, 8'h00, 32'd0,   32'd0,          1'b0},
    '{OP_LD, 8'h10, 32'd0,   32'd333,        1'b1},
    '{OP_CM, 8'h00, 32'd0,   32'd0,          1'b0},
    '{OP_CM, 8'h20, 32'd222, 32'd0,          1'b1},
    '{OP_CM, 8'h10, 32'd333, 32'd0,          1'b1},
    '{OP_ID, 8'h40, 32'd444, 32'd0,          1'b1},
    '{OP_ID, 8'h00, 32'd0,   32'd0,          1'b0},
    '{OP_LD, 8'h10, 32'd0,   32'd333,        1'b0},
    '{OP_LD, 8'h20, 32'd0,   32'd222,        1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, cmt = 1'b0, ld_valid = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ready, ld_vo, ld_fwd, mem_req, mem_we;
  logic [DW-1:0] ld_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sb_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready),
    .cmt_i(cmt), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_valid_o(ld_vo), .ld_fwd_o(ld_fwd), .ld_data_o(ld_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic c, input logic l, input logic [AW-1:0] la);
    @(negedge clk);
    st_valid = s; st_addr = sa; st_data = sd; cmt = c; ld_valid = l; ld_addr = la;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic exp_wr(input string req, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    chk({req, " write"}, 32'(mem_we), 32'(we));
    if (we) begin
      chk({req, " addr"}, 32'(mem_addr), 32'(a));
      chk({req, " data"}, mem_wdata, d);
    end
  endtask

  task automatic exp_ld(input string req, input logic f, input logic [DW-1:0] d);
    chk({req, " valid"}, 32'(ld_vo), 32'd1);
    chk({req, " fwd"}, 32'(ld_fwd), 32'(f));
    chk({req, " data"}, ld_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #2;
    chk("R1 ready in reset", 32'(st_ready), 32'd1);
    chk("R1 req in reset", 32'(mem_req), 32'd0);
    chk("R1 ld_valid in reset", 32'(ld_vo), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", 32'(st_ready), 32'd1);
    chk("R1 req after reset", 32'(mem_req), 32'd0);
    tick();
    chk("R1 ld_valid after reset", 32'(ld_vo), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      drive(v.op == OP_ST, v.a, v.d, v.op == OP_CM, v.op == OP_LD, v.a);
      case (v.op)
        OP_ST: chk("R8 st_ready", 32'(st_ready), 32'(v.f));
        OP_LD: begin
          chk("R4 load owns port", 32'(mem_req && !mem_we), 32'd1);
          chk("R4 read addr", 32'(mem_addr), 32'(v.a));
        end
        default: exp_wr("R2/R3 drain", v.f, v.a, v.d);
      endcase
      tick();
      if (v.op == OP_LD) exp_ld("R5/R6 load", v.f, v.e);
    end

    // R11 retire with nothing finished
    drive(0, '0, '0, 1, 0, '0); tick();
    drive(1, 8'h70, 32'd5, 0, 0, '0); tick();
    drive(0, '0, '0, 0, 0, '0);
    exp_wr("R11 no write after empty retire", 1'b0, '0, '0);
    tick();

    // R7 top-bit alias must not match
    drive(1, 8'h10, 32'd7, 0, 0, '0); tick();
    drive(0, '0, '0, 0, 1, 8'h90); tick();
    exp_ld("R7 full address", 1'b0, 32'hA000_0090);

    // R10 same-cycle store is younger than the load
    drive(1, 8'h60, 32'd9, 0, 1, 8'h60); tick();
    exp_ld("R10 same cycle", 1'b0, 32'hA000_0060);
    drive(0, '0, '0, 0, 1, 8'h60); tick();
    exp_ld("R6 next load", 1'b1, 32'd9);

    // R8 full, then R9 wrap
    drive(1, 8'h70, 32'd8, 0, 0, '0); tick();
    drive(1, 8'h20, 32'd1, 0, 0, '0);
    chk("R8 full ready", 32'(st_ready), 32'd0);
    tick();
    drive(0, '0, '0, 1, 0, '0); tick();
    drive(0, '0, '0, 0, 0, '0);
    exp_wr("R3 drain", 1'b1, 8'h70, 32'd5);
    tick();
    drive(1, 8'h10, 32'd6, 0, 0, '0);
    chk("R9 ready after drain", 32'(st_ready), 32'd1);
    tick();
    drive(0, '0, '0, 0, 1, 8'h10); tick();
    exp_ld("R9 wrapped youngest", 1'b1, 32'd6);

    // R3 ordered drain of remaining entries
    drive(0, '0, '0, 1, 0, '0); exp_wr("R3 first retire", 1'b0, '0, '0); tick();
    drive(0, '0, '0, 1, 0, '0); exp_wr("R3 order 1", 1'b1, 8'h10, 32'd7); tick();
    drive(0, '0, '0, 1, 0, '0); exp_wr("R3 order 2", 1'b1, 8'h60, 32'd9); tick();
    drive(0, '0, '0, 1, 0, '0); exp_wr("R3 order 3", 1'b1, 8'h70, 32'd8); tick();
    drive(0, '0, '0, 0, 0, '0); exp_wr("R3 order 4", 1'b1, 8'h10, 32'd6); tick();
    drive(0, '0, '0, 0, 0, '0); exp_wr("R2 empty", 1'b0, '0, '0); tick();
    chk("R3 final mem 10", mem[8'h10], 32'd6);
    chk("R3 final mem 70", mem[8'h70], 32'd8);
    chk("R3 final mem 20 untouched by dropped store", mem[8'h20], 32'd222);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule